// File: doc/BRIEF.md
# Thread-Mapped FIFO Flag Generator

This block drives the flow-control flags of a parallel interface that carries four logical threads. The active thread is taken from one of two places. It can come from two address pins, or from a thread field written by software. A mode bit picks which one is used. Each thread points at one buffer socket through its own map field. The flags describe whichever socket that thread currently points at. The buffer engine supplies every socket's fill level directly, so the flags do not depend on any interface state machine.

Each socket carries a direction bit that is set when the socket is initialised:

- **Socket read by the interface:** a flag reports whether the socket is empty or nearly empty.
- **Socket written by the interface:** a flag reports whether the socket is full or nearly full.

Each flag output is configured on its own:

- **Exact or partial:** an exact flag tracks the empty or full edge. A partial flag compares the fill level against the selected thread's watermark.
- **Polarity:** the flag can be active-high or active-low.

In every case a raised flag means "blocked". Flags are registered. Until the socket configuration is declared complete, every flag shows blocked.

Top module: `thread_flag_gen`

## Requirements
- R1: The active thread is `reg_thread` when `use_reg_thread` is 1, and `addr_pins` when it is 0.
- R2: Thread t uses socket `thread_map[t*SW +: SW]`. That socket supplies the fill level from `sock_level` and the direction from `sock_is_read`. The watermark is always that of thread t, taken from `thread_wmark[t*LEVEL_W +: LEVEL_W]`.
- R3: Read socket (`sock_is_read`=1) with an exact flag (`flag_partial`=0): the flag is blocked exactly when the fill level is 0.
- R4: Written socket (`sock_is_read`=0) with an exact flag: the flag is blocked exactly when the fill level is at least CAPACITY.
- R5: Read socket with a partial flag (`flag_partial`=1): the flag is blocked exactly when the fill level is less than or equal to the thread's watermark.
- R6: Written socket with a partial flag: the flag is blocked exactly when the fill level plus the watermark is at least CAPACITY. A watermark larger than CAPACITY therefore keeps the flag blocked.
- R7: `flag_out[i]` equals the blocked condition when `flag_active_high[i]`=1, and its inverse when it is 0. Polarity takes effect in the same cycle.
- R8: The blocked condition is registered. It reflects the inputs present at the previous rising clock edge.
- R9: The blocked condition is 1 for every flag in the following cases:
  - during reset;
  - in the cycle after any edge at which `cfg_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_pins | input | 2 | Thread number from the interface pins |
| use_reg_thread | input | 1 | 1: thread comes from `reg_thread`; 0: from `addr_pins` |
| reg_thread | input | 2 | Thread number from the configuration register |
| thread_map | input | 4*SW | Socket index for each thread |
| thread_wmark | input | 4*LEVEL_W | Watermark for each thread |
| sock_level | input | NUM_SOCKETS*LEVEL_W | Fill level of each socket |
| sock_is_read | input | NUM_SOCKETS | Direction per socket: 1 read out, 0 written |
| cfg_done | input | 1 | Socket configuration complete |
| flag_partial | input | NUM_FLAGS | Per flag: 1 partial (watermark), 0 exact |
| flag_active_high | input | NUM_FLAGS | Per flag polarity: 1 active-high |
| flag_out | output | NUM_FLAGS | Flag outputs |

## Verification
The assertions cover five conditions on every cycle, for each flag:

- the blocked state while configuration is incomplete;
- the four edges where the selected socket is exactly empty, exactly full, at its partial-empty threshold, or at its partial-full threshold.

Some behaviour only the bench scenarios can show:

- that flags drop again away from those edges;
- that switching the thread source, the map, or a watermark moves the flag to a different socket or threshold;
- that polarity inverts the output without delay.

The random stimulus favours levels of 0, 1, CAPACITY-1, CAPACITY and above. It also includes watermarks beyond CAPACITY, because the comparisons can go wrong at those values.

// File: rtl/thread_flag_gen.sv
module thread_flag_gen #(
  parameter int NUM_SOCKETS = 4,
  parameter int LEVEL_W     = 8,
  parameter int CAPACITY    = 200,
  parameter int NUM_FLAGS   = 2,
  parameter int SW          = $clog2(NUM_SOCKETS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     addr_pins,
  input  logic                           use_reg_thread,
  input  logic [1:0]                     reg_thread,
  input  logic [4*SW-1:0]                thread_map,
  input  logic [4*LEVEL_W-1:0]           thread_wmark,
  input  logic [NUM_SOCKETS*LEVEL_W-1:0] sock_level,
  input  logic [NUM_SOCKETS-1:0]         sock_is_read,
  input  logic                           cfg_done,
  input  logic [NUM_FLAGS-1:0]           flag_partial,
  input  logic [NUM_FLAGS-1:0]           flag_active_high,
  output logic [NUM_FLAGS-1:0]           flag_out
);
  localparam int CW = LEVEL_W + 2;

  logic [1:0]           thread;
  logic [SW-1:0]        sock;
  logic [LEVEL_W-1:0]   level, wmark;
  logic                 is_read;
  logic [CW-1:0]        sum;
  logic                 is_empty, is_full, part_empty, part_full;
  logic [NUM_FLAGS-1:0] blocked, flag_q;

  assign thread  = use_reg_thread ? reg_thread : addr_pins;
  assign sock    = thread_map[thread*SW +: SW];
  assign level   = sock_level[sock*LEVEL_W +: LEVEL_W];
  assign wmark   = thread_wmark[thread*LEVEL_W +: LEVEL_W];
  assign is_read = sock_is_read[sock];
  assign sum     = CW'(level) + CW'(wmark);

  assign is_empty   = (level == '0);
  assign is_full    = (CW'(level) >= CW'(CAPACITY));
  assign part_empty = (level <= wmark);
  assign part_full  = (sum >= CW'(CAPACITY));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign blocked[i] = is_read ? (flag_partial[i] ? part_empty : is_empty)
                                : (flag_partial[i] ? part_full  : is_full);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= '1;
    else if (!cfg_done) flag_q <= '1;
    else                flag_q <= blocked;
  end

  assign flag_out = flag_q ^ ~flag_active_high;
endmodule

// File: rtl/thread_flag_gen_chk.sv
module thread_flag_gen_chk #(
  parameter int NUM_SOCKETS = 4,
  parameter int LEVEL_W     = 8,
  parameter int CAPACITY    = 200,
  parameter int NUM_FLAGS   = 2,
  parameter int SW          = $clog2(NUM_SOCKETS)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [1:0]                     addr_pins,
  input logic                           use_reg_thread,
  input logic [1:0]                     reg_thread,
  input logic [4*SW-1:0]                thread_map,
  input logic [4*LEVEL_W-1:0]           thread_wmark,
  input logic [NUM_SOCKETS*LEVEL_W-1:0] sock_level,
  input logic [NUM_SOCKETS-1:0]         sock_is_read,
  input logic                           cfg_done,
  input logic [NUM_FLAGS-1:0]           flag_partial,
  input logic [NUM_FLAGS-1:0]           flag_active_high,
  input logic [NUM_FLAGS-1:0]           flag_out
);
  logic [1:0]         t;
  logic [SW-1:0]      s;
  logic [LEVEL_W-1:0] lv, wm;
  logic               rd;

  assign t  = use_reg_thread ? reg_thread : addr_pins;
  assign s  = thread_map[t*SW +: SW];
  assign lv = sock_level[s*LEVEL_W +: LEVEL_W];
  assign wm = thread_wmark[t*LEVEL_W +: LEVEL_W];
  assign rd = sock_is_read[s];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
    // R9
    unconfigured_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |=> (flag_out[i] == flag_active_high[i]));
    // R3
    empty_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && rd && !flag_partial[i] && lv == '0) |=> (flag_out[i] == flag_active_high[i]));
    // R4
    full_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !rd && !flag_partial[i] && int'(lv) == CAPACITY) |=> (flag_out[i] == flag_active_high[i]));
    // R5
    part_empty_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && rd && flag_partial[i] && lv == wm) |=> (flag_out[i] == flag_active_high[i]));
    // R6
    part_full_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !rd && flag_partial[i] && (int'(lv) + int'(wm)) == CAPACITY - 1)
        |=> (flag_out[i] != flag_active_high[i]));
  end
endmodule

bind thread_flag_gen thread_flag_gen_chk #(
  .NUM_SOCKETS(NUM_SOCKETS), .LEVEL_W(LEVEL_W), .CAPACITY(CAPACITY),
  .NUM_FLAGS(NUM_FLAGS), .SW(SW)
) chk (.*);

// File: tb/thread_flag_gen_test.sv
`timescale 1ns/1ps
module thread_flag_gen_test;
  localparam int NS = 4, LW = 8, CAP = 200, NF = 2, SW = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] addr_pins = 0, reg_thread = 0;
  logic use_reg_thread = 0, cfg_done = 0;
  logic [4*SW-1:0] thread_map = 0;
  logic [4*LW-1:0] thread_wmark = 0;
  logic [NS*LW-1:0] sock_level = 0;
  logic [NS-1:0] sock_is_read = 0;
  logic [NF-1:0] flag_partial = 0, flag_active_high = 0, flag_out;

  int checks = 0, fails = 0;

  thread_flag_gen #(.NUM_SOCKETS(NS), .LEVEL_W(LW), .CAPACITY(CAP), .NUM_FLAGS(NF)) uut (
    .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .use_reg_thread(use_reg_thread),
    .reg_thread(reg_thread), .thread_map(thread_map), .thread_wmark(thread_wmark),
    .sock_level(sock_level), .sock_is_read(sock_is_read), .cfg_done(cfg_done),
    .flag_partial(flag_partial), .flag_active_high(flag_active_high), .flag_out(flag_out));

  always #10 clk = ~clk;

  function automatic bit model(int f);
    int th, sk, lv, wm;
    if (!cfg_done) return 1'b1;
    th = use_reg_thread ? int'(reg_thread) : int'(addr_pins);
    sk = int'(thread_map[th*SW +: SW]);
    lv = int'(sock_level[sk*LW +: LW]);
    wm = int'(thread_wmark[th*LW +: LW]);
    if (sock_is_read[sk]) return flag_partial[f] ? (lv <= wm) : (lv == 0);
    return flag_partial[f] ? (lv + wm >= CAP) : (lv >= CAP);
  endfunction

  function automatic string tag(int f);
    int th, sk;
    if (!cfg_done) return "R9";
    th = use_reg_thread ? int'(reg_thread) : int'(addr_pins);
    sk = int'(thread_map[th*SW +: SW]);
    if (sock_is_read[sk]) return flag_partial[f] ? "R5 (R1/R2/R7/R8)" : "R3 (R1/R2/R7/R8)";
    return flag_partial[f] ? "R6 (R1/R2/R7/R8)" : "R4 (R1/R2/R7/R8)";
  endfunction

  task automatic check(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: flag actual %b expected %b", t, act, exp);
    end
  endtask

  task automatic step();
    bit [NF-1:0] e;
    string tg [NF];
    for (int f = 0; f < NF; f++) begin
      e[f] = model(f);
      tg[f] = tag(f);
    end
    @(negedge clk);
    for (int f = 0; f < NF; f++)
      check(tg[f], flag_out[f], e[f] ^ ~flag_active_high[f]);
  endtask

  function automatic logic [LW-1:0] pick_level();
    case ($urandom % 7)
      0: return 0;
      1: return 1;
      2: return LW'(CAP - 1);
      3: return LW'(CAP);
      4: return LW'(CAP + 1 + ($urandom % (255 - CAP)));
      default: return LW'($urandom);
    endcase
  endfunction

  task automatic randomize_inputs();
    addr_pins = 2'($urandom);
    reg_thread = 2'($urandom);
    use_reg_thread = 1'($urandom);
    thread_map = 8'($urandom);
    for (int i = 0; i < NS; i++) sock_level[i*LW +: LW] = pick_level();
    for (int i = 0; i < 4; i++)
      thread_wmark[i*LW +: LW] = ($urandom % 4 == 0) ? LW'($urandom) : LW'($urandom % 20);
    sock_is_read = 4'($urandom);
    flag_partial = 2'($urandom);
    flag_active_high = 2'($urandom);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    flag_active_high = 2'b10;
    repeat (3) @(negedge clk);
    // R9: reset state shows blocked
    for (int f = 0; f < NF; f++) check("R9 reset", flag_out[f], 1'b1 ^ ~flag_active_high[f]);
    rst_n = 1;
    // R9: unconfigured keeps blocked despite levels that would release
    for (int k = 0; k < 5; k++) begin
      randomize_inputs();
      cfg_done = 0;
      step();
    end

    // Directed: R1 thread source selection, R2 mapping
    cfg_done = 1;
    flag_partial = 2'b00; flag_active_high = 2'b11;
    sock_is_read = 4'b1111;
    thread_map = {2'd0, 2'd3, 2'd2, 2'd1};      // t0->s1 t1->s2 t2->s3 t3->s0
    sock_level = {8'd9, 8'd7, 8'd0, 8'd5};      // s3=9 s2=7 s1=0 s0=5
    addr_pins = 2'd0; reg_thread = 2'd1; use_reg_thread = 0;
    step();   // pins thread 0 -> socket 1 empty -> R1 blocked
    use_reg_thread = 1;
    step();   // reg thread 1 -> socket 2 level 7 -> R1 not blocked
    thread_map[3:2] = 2'd1;                     // remap thread 1 to socket 1
    step();   // R2 remap -> empty
    // R4 exact full edges
    sock_is_read = 4'b0000; thread_map[3:2] = 2'd2;
    sock_level[2*LW +: LW] = LW'(CAP - 1); step();
    sock_level[2*LW +: LW] = LW'(CAP);     step();
    // R5/R6 watermark edges, watermark of thread 1
    flag_partial = 2'b11;
    thread_wmark[LW +: LW] = 8'd20;
    sock_level[2*LW +: LW] = LW'(CAP - 21); step();   // R6 not blocked
    sock_level[2*LW +: LW] = LW'(CAP - 20); step();   // R6 blocked
    thread_wmark[LW +: LW] = 8'd250; sock_level[2*LW +: LW] = 0; step(); // R6 big watermark
    sock_is_read = 4'b1111; thread_wmark[LW +: LW] = 8'd7;
    step();   // R5 level 0 <= 7
    sock_level[2*LW +: LW] = 8'd7; step();   // R5 at watermark
    sock_level[2*LW +: LW] = 8'd8; step();   // R5 above
    // R7 polarity flips
    flag_active_high = 2'b01; step();
    flag_active_high = 2'b10; step();
    // R9 configuration withdrawn
    cfg_done = 0; step();
    cfg_done = 1; step();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      randomize_inputs();
      cfg_done = ($urandom % 16) != 0;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule